// File: doc/BRIEF.md
# Interrupt Acceptance and WAIT Stall Controller

This unit sits beside an instruction sequencer and decides, at each instruction boundary, whether the core should divert into an interrupt. Two external request lines are watched. The maskable request is a level, and it is honoured only while the internal interrupt-enable flag is set. The non-maskable request is an edge, and it is honoured whatever the flag holds. When a maskable request is accepted, the unit issues a one-cycle pulse that starts the core's acknowledge sequence. When a non-maskable request is accepted, it issues a separate one-cycle pulse that needs no acknowledge. Accepting either kind clears the enable flag. The flag stays clear until software sets it again.

The unit also governs the WAIT instruction. While the core reports that WAIT is executing, a coprocessor-driven test input selects the outcome. When the input is low, WAIT passes as a no-op. When it is high, the unit holds the core stalled until the input falls. All three external pins pass through a synchronizer of configurable depth before any decision uses them.

Top module: `irq_wait_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge leaves `ie_flag`, `ack_start`, `nmi_take` and `core_stall` at 0 and discards any latched non-maskable request.
- R2: After a clock edge that samples `flag_set`=1 with `flag_clr`=0, `ie_flag` is 1. After an edge that samples `flag_clr`=1, `ie_flag` is 0. When both are sampled at 1 together, the clear wins.
- R3: While `ie_flag` is 0, a high `intr_req` never produces `ack_start`, at a boundary or anywhere else.
- R4: When `boundary` is 1 in a cycle where the synchronized `intr_req` is 1, `ie_flag` is 1 and no non-maskable request is pending, `ack_start` is 1 for exactly the next cycle. Without `boundary`, no `ack_start` occurs.
- R5: A rising edge of the synchronized `nmi_in` is latched. At the next cycle with `boundary`=1, `nmi_take` pulses for one cycle regardless of `ie_flag`. A level held high produces only one take.
- R6: When a non-maskable request is pending and `intr_req` is high at the same boundary, `nmi_take` pulses and `ack_start` does not.
- R7: The edge that raises `ack_start` or `nmi_take` also clears `ie_flag`. This overrides a `flag_set` sampled on that same edge.
- R8: `core_stall` is 1 in the cycle after an edge that samples `wait_exec`=1 with the synchronized `wait_test`=1. It is 0 after any edge where either of them is 0, so WAIT with a low test input does not stall.
- R9: Each of `intr_req`, `nmi_in` and `wait_test` passes through `SYNC_STAGES` flops before use. With the default of 2, a rise of `wait_test` under a held `wait_exec` shows on `core_stall` after exactly three edges.
- R10: `ack_start` and `nmi_take` are never high together, and `ack_start` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intr_req | input | 1 | Maskable interrupt request, level, asynchronous |
| nmi_in | input | 1 | Non-maskable request, rising-edge active, asynchronous |
| wait_test | input | 1 | Coprocessor busy input: 1 makes WAIT stall |
| boundary | input | 1 | Core is at an instruction boundary this cycle |
| flag_set | input | 1 | Request to set the interrupt-enable flag |
| flag_clr | input | 1 | Request to clear the interrupt-enable flag |
| wait_exec | input | 1 | Core is executing a WAIT instruction |
| ack_start | output | 1 | One-cycle pulse: begin maskable acknowledge sequence |
| nmi_take | output | 1 | One-cycle pulse: divert to the non-maskable handler |
| core_stall | output | 1 | Hold the core while WAIT is blocked |
| ie_flag | output | 1 | Current interrupt-enable flag |

## Verification
Several relations are checked by assertions on every cycle. The two take pulses are exclusive, and a maskable take needs a preceding boundary with the flag set. Any take leaves the flag clear. A stall always follows a sampled WAIT. Flag set and clear requests take effect on the next edge. Other behaviour only the bench's scenarios can show: the ordering of a non-maskable request ahead of a maskable one, the single take for a held non-maskable level, the exact synchronizer latency, and the rule that a masked request leaves no trace once the flag is set later. The bench shows these by comparing every output each cycle against a cycle-level model under directed and random stimulus.

// File: rtl/irq_wait_pkg.sv
package irq_wait_pkg;

    // Outcome of the boundary decision in one cycle
    typedef enum logic [1:0] {
        TK_NONE      = 2'd0,
        TK_NMI       = 2'd1,
        TK_MASKABLE  = 2'd2
    } take_e;

    // Synchronized view of the asynchronous pins
    typedef struct packed {
        logic intr;
        logic nmi;
        logic test;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    // Non-maskable first; maskable only with the flag set
    function automatic take_e pick_take(input logic at_bnd,
                                        input logic nmi_pend,
                                        input logic intr_lvl,
                                        input logic ie);
        take_e r;
        r = TK_NONE;
        if (at_bnd) begin
            if (nmi_pend)
                r = TK_NMI;
            else if (intr_lvl && ie)
                r = TK_MASKABLE;
        end
        return r;
    endfunction

    // Flag update: a take dominates, then clear, then set
    function automatic logic next_ie(input logic cur,
                                     input logic take_any,
                                     input logic set_req,
                                     input logic clr_req);
        logic r;
        if (take_any)
            r = 1'b0;
        else if (clr_req)
            r = 1'b0;
        else if (set_req)
            r = 1'b1;
        else
            r = cur;
        return r;
    endfunction

endpackage

// File: rtl/iwc_sync.sv
module iwc_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] stage [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++)
                        stage[i] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < STAGES; i++)
                        stage[i] <= stage[i-1];
                end
            end
            assign q = stage[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/iwc_nmi_latch.sv
module iwc_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_lvl,
    input  logic serviced,
    output logic pending
);
    logic prev_lvl;
    logic rise;

    assign rise = nmi_lvl & ~prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= 1'b0;
            pending  <= 1'b0;
        end else begin
            prev_lvl <= nmi_lvl;
            // A fresh edge in the service cycle stays pending
            pending  <= rise | (pending & ~serviced);
        end
    end
endmodule

// File: rtl/iwc_ie_flag.sv
module iwc_ie_flag
    import irq_wait_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic take_any,
    output logic ie
);
    always_ff @(posedge clk) begin
        if (rst)
            ie <= 1'b0;
        else
            ie <= next_ie(ie, take_any, set_req, clr_req);
    end
endmodule

// File: rtl/iwc_arbiter.sv
module iwc_arbiter
    import irq_wait_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  at_bnd,
    input  logic  nmi_pend,
    input  logic  intr_lvl,
    input  logic  ie,
    output take_e take_now,
    output logic  ack_start,
    output logic  nmi_take
);
    assign take_now = pick_take(at_bnd, nmi_pend, intr_lvl, ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_start <= 1'b0;
            nmi_take  <= 1'b0;
        end else begin
            ack_start <= (take_now == TK_MASKABLE);
            nmi_take  <= (take_now == TK_NMI);
        end
    end
endmodule

// File: rtl/irq_wait_unit.sv
module irq_wait_unit
    import irq_wait_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic intr_req,
    input  logic nmi_in,
    input  logic wait_test,
    input  logic boundary,
    input  logic flag_set,
    input  logic flag_clr,
    input  logic wait_exec,
    output logic ack_start,
    output logic nmi_take,
    output logic core_stall,
    output logic ie_flag
);
    pins_t raw_pins;
    pins_t sync_pins;
    take_e take_now;
    logic  nmi_pend;
    logic  take_any;

    assign raw_pins = '{intr: intr_req, nmi: nmi_in, test: wait_test};

    iwc_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    iwc_nmi_latch u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_lvl  (sync_pins.nmi),
        .serviced (take_now == TK_NMI),
        .pending  (nmi_pend)
    );

    iwc_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .at_bnd    (boundary),
        .nmi_pend  (nmi_pend),
        .intr_lvl  (sync_pins.intr),
        .ie        (ie_flag),
        .take_now  (take_now),
        .ack_start (ack_start),
        .nmi_take  (nmi_take)
    );

    assign take_any = (take_now != TK_NONE);

    iwc_ie_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_req  (flag_set),
        .clr_req  (flag_clr),
        .take_any (take_any),
        .ie       (ie_flag)
    );

    // WAIT gate: stall only while WAIT runs and the test input is high
    always_ff @(posedge clk) begin
        if (rst)
            core_stall <= 1'b0;
        else
            core_stall <= wait_exec & sync_pins.test;
    end
endmodule

// File: rtl/irq_wait_unit_chk.sv
module irq_wait_unit_chk (
    input logic clk,
    input logic rst,
    input logic boundary,
    input logic flag_set,
    input logic flag_clr,
    input logic wait_exec,
    input logic ack_start,
    input logic nmi_take,
    input logic core_stall,
    input logic ie_flag
);
    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(ack_start && nmi_take));

    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        ack_start |=> !ack_start);

    p_ack_gated_r4: assert property (@(posedge clk) disable iff (rst)
        ack_start |-> ($past(boundary) && $past(ie_flag)));

    p_nmi_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        nmi_take |-> $past(boundary));

    p_take_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_start || nmi_take) |-> !ie_flag);

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (flag_set && !flag_clr) |=> (ie_flag || ack_start || nmi_take));

    p_clr_r2: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> !ie_flag);

    p_stall_wait_r8: assert property (@(posedge clk) disable iff (rst)
        !wait_exec |=> !core_stall);
endmodule

bind irq_wait_unit irq_wait_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .flag_set   (flag_set),
    .flag_clr   (flag_clr),
    .wait_exec  (wait_exec),
    .ack_start  (ack_start),
    .nmi_take   (nmi_take),
    .core_stall (core_stall),
    .ie_flag    (ie_flag)
);

// File: tb/irq_wait_unit_test.sv
module irq_wait_unit_test;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic intr_req = 0, nmi_in = 0, wait_test = 0, boundary = 0;
    logic flag_set = 0, flag_clr = 0, wait_exec = 0;
    logic ack_start, nmi_take, core_stall, ie_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_wait_unit #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .intr_req(intr_req), .nmi_in(nmi_in),
        .wait_test(wait_test), .boundary(boundary), .flag_set(flag_set),
        .flag_clr(flag_clr), .wait_exec(wait_exec), .ack_start(ack_start),
        .nmi_take(nmi_take), .core_stall(core_stall), .ie_flag(ie_flag)
    );

    // ---------------- cycle model built from the requirements ----------------
    logic [SYNC-1:0] m_i = '0, m_n = '0, m_t = '0;
    logic m_nq = 0, m_pend = 0, m_ie = 0, m_ack = 0, m_nt = 0, m_stall = 0;

    function automatic logic exp_ie(logic cur, logic take, logic s, logic c);
        if (take) return 1'b0;       // R7
        if (c)    return 1'b0;       // R2 clear wins
        if (s)    return 1'b1;
        return cur;
    endfunction

    always @(posedge clk) begin
        logic i_s, n_s, t_s, rise, tk_n, tk_i;
        if (rst) begin
            m_i = '0; m_n = '0; m_t = '0;
            m_nq = 0; m_pend = 0; m_ie = 0; m_ack = 0; m_nt = 0; m_stall = 0;
        end else begin
            i_s = m_i[SYNC-1]; n_s = m_n[SYNC-1]; t_s = m_t[SYNC-1];
            rise = n_s & ~m_nq;
            tk_n = boundary & m_pend;
            tk_i = boundary & ~m_pend & i_s & m_ie;
            m_pend  = rise | (m_pend & ~tk_n);
            m_nq    = n_s;
            m_ie    = exp_ie(m_ie, tk_n | tk_i, flag_set, flag_clr);
            m_ack   = tk_i;
            m_nt    = tk_n;
            m_stall = wait_exec & t_s;
            m_i = {m_i[SYNC-2:0], intr_req};
            m_n = {m_n[SYNC-2:0], nmi_in};
            m_t = {m_t[SYNC-2:0], wait_test};
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, sampled at the falling edge
    int ack_seen = 0, nt_seen = 0;
    always @(negedge clk) begin
        if (!done) begin
            check("R2 ie_flag", ie_flag, m_ie);
            check("R4 ack_start", ack_start, m_ack);
            check("R5 nmi_take", nmi_take, m_nt);
            check("R8 core_stall", core_stall, m_stall);
            check("R10 exclusive", ack_start & nmi_take, 1'b0);
            if (ack_start || nmi_take) check("R7 flag cleared by take", ie_flag, 1'b0);
            ack_seen += ack_start;
            nt_seen  += nmi_take;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        boundary = 0; flag_set = 0; flag_clr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        step(4);
        // R1: reset state
        check("R1 ie", ie_flag, 0); check("R1 ack", ack_start, 0);
        check("R1 nmi", nmi_take, 0); check("R1 stall", core_stall, 0);
        rst = 0;
        step(2);

        // R3: masked request at many boundaries
        intr_req = 1; ack_seen = 0;
        for (int k = 0; k < 20; k++) begin boundary = k[0]; step(1); end
        idle(); step(3);
        check("R3 masked acks", ack_seen != 0, 1'b0);

        // R2: set, then set+clr together
        flag_set = 1; step(1); flag_set = 0;
        check("R2 set", ie_flag, 1);
        flag_set = 1; flag_clr = 1; step(1); idle();
        check("R2 clear wins", ie_flag, 0);

        // R4: request with flag set but no boundary, then a boundary
        flag_set = 1; step(1); idle(); ack_seen = 0;
        step(6);
        check("R4 no boundary", ack_seen != 0, 1'b0);
        boundary = 1; step(1); boundary = 0;
        check("R4 ack pulse", ack_start, 1);
        step(1);
        check("R4 single pulse", ack_start, 0);
        intr_req = 0;

        // R5: NMI with flag clear, held high across boundaries
        nt_seen = 0; nmi_in = 1;
        for (int k = 0; k < 12; k++) begin boundary = (k % 3 == 2); step(1); end
        idle(); step(2);
        check("R5 one take per edge", nt_seen == 1, 1'b1);
        nmi_in = 0; step(4);

        // R6: both pending at the same boundary
        flag_set = 1; intr_req = 1; nmi_in = 1; step(1); idle();
        step(SYNC + 2);
        ack_seen = 0; nt_seen = 0;
        boundary = 1; step(1); boundary = 0;
        check("R6 nmi first", nmi_take, 1);
        check("R6 no ack", ack_start, 0);
        boundary = 1; step(3); idle(); step(1);
        check("R6 no later ack (flag cleared)", ack_seen == 0, 1'b1);
        nmi_in = 0; intr_req = 0; step(3);

        // R7: set request on the take edge
        flag_set = 1; step(1); flag_set = 0; intr_req = 1; step(SYNC + 1);
        boundary = 1; flag_set = 1; step(1); idle();
        check("R7 take overrides set", ie_flag, 0);
        check("R7 ack", ack_start, 1);
        intr_req = 0; step(3);

        // R8 / R9: WAIT with test low and high
        wait_exec = 1; wait_test = 0; step(5);
        check("R8 no stall test low", core_stall, 0);
        wait_test = 1; step(SYNC);
        check("R9 stall not yet", core_stall, 0);
        step(1);
        check("R9 stall after sync", core_stall, 1);
        wait_test = 0; step(SYNC + 1);
        check("R8 released", core_stall, 0);
        wait_exec = 0; step(2);

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            intr_req  = ($urandom % 3) == 0;
            nmi_in    = ($urandom % 8) == 0 ? ~nmi_in : nmi_in;
            wait_test = ($urandom % 4) == 0 ? ~wait_test : wait_test;
            boundary  = ($urandom % 3) == 0;
            flag_set  = ($urandom % 6) == 0;
            flag_clr  = ($urandom % 9) == 0;
            wait_exec = ($urandom % 2) == 0;
            if (($urandom % 400) == 0) rst = 1; else rst = 0;
            step(1);
        end
        rst = 0; idle(); step(3);
        finish_run();
    end
endmodule